// File: doc/BRIEF.md
# UART Baud Rate Generator

This block turns a peripheral clock and a 16-bit divisor into the two timing strobes that a UART needs. The first is a sample strobe at eight times the bit rate. The second is a bit strobe at the bit rate. Each strobe is a single-cycle pulse. The sample strobe repeats every (divisor + 1) clocks. The bit strobe fires together with every eighth sample strobe, so the bit rate is the clock frequency divided by 8 × (divisor + 1).

A divisor of 0 is raised to 1. This caps the bit rate at one sixteenth of the clock: 6.25 Mbit/s from a 100 MHz clock. From 100 MHz, a divisor of 2603 gives 4800 bit/s, a divisor of 324 gives about 38462 bit/s, and a divisor of 5207 gives about 2400 bit/s (41664 clocks per bit).

The divisor is copied into the down-counter only when the counter reloads. A divisor that changes in the middle of a period therefore never shortens or stretches the period in progress. While the enable is low, the counter is held at its reload value and no strobes are produced.

Top module: `uart_rate_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sample_tick_o` and `bit_tick_o` are both low.
- R2: With the enable high and a constant divisor D ≥ 1, consecutive `sample_tick_o` pulses are exactly D+1 clock cycles apart.
- R3: `bit_tick_o` pulses exactly every 8×(D+1) cycles. Each pulse falls in the same cycle as a `sample_tick_o` pulse.
- R4: A divisor of 0 behaves as 1. The sample period is then 2 cycles and the bit period is 16 cycles, which is the one-sixteenth-of-clock ceiling.
- R5: While `enable_i` is low, neither strobe pulses. Once `enable_i` is first sampled high at a clock edge, the first sample strobe appears after the (D+1)th edge, counting that edge as the first. The first bit strobe appears after the 8×(D+1)th edge.
- R6: A divisor change in the middle of a period does not alter that period. The next period uses the new value.
- R7: Each strobe is high for exactly one cycle at a time.
- R8: `bit_tick_o` is never high without `sample_tick_o`.
- R9: The full 16-bit divisor range is honoured. A divisor of 5207 gives a 5208-cycle sample period, and a divisor of 324 gives a 2600-cycle bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the generator when high |
| divisor_i | input | 16 | Baud-select value D; sample period is D+1 clocks |
| sample_tick_o | output | 1 | One-cycle pulse at 8× bit rate |
| bit_tick_o | output | 1 | One-cycle pulse at the bit rate |

## Verification
The bench measures the exact cycle spacing of both strobes for small, medium and large divisors. An off-by-one in the reload would show up here as periods of D or D+2 instead of D+1. It drives divisor 0 to confirm the clamp: without the clamp, a strobe would stay high every cycle and break the one-sixteenth ceiling. It changes the divisor in the middle of a period: a design that loads the divisor at once would cut that period short. It also checks the first-strobe latency after enable. A design that keeps its old count or eighth-phase while disabled would pulse early.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;
  localparam int unsigned DIV_W      = 16;
  localparam int unsigned OVERSAMPLE = 8;
  localparam int unsigned MIN_DIV    = 1;
  localparam int unsigned PHASE_W    = $clog2(OVERSAMPLE);

  typedef logic [DIV_W-1:0]   div_t;
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/rate_reload_value.sv
module rate_reload_value #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned MIN_DIV = 1
) (
  input  logic [DIV_W-1:0] divisor_i,
  output logic [DIV_W-1:0] reload_o
);
  localparam logic [DIV_W-1:0] FloorVal = DIV_W'(MIN_DIV);

  generate
    if (MIN_DIV == 0) begin : g_pass
      assign reload_o = divisor_i;
    end else begin : g_clamp
      always_comb begin
        if (divisor_i < FloorVal) reload_o = FloorVal;
        else                      reload_o = divisor_i;
      end
    end
  endgenerate
endmodule

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [DIV_W-1:0] reload_i,
  output logic             reload_o,
  output logic             sample_tick_o
);
  localparam logic [DIV_W-1:0] Zero = '0;
  localparam logic [DIV_W-1:0] One  = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             reload_w;

  assign reload_w = enable_i && (cnt_q == Zero);
  assign reload_o = reload_w;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!enable_i) begin
      cnt_d = reload_i;
    end else if (reload_w) begin
      cnt_d  = reload_i;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q - One;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= Zero;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign sample_tick_o = tick_q;

  // R7: a strobe never lasts two cycles
  assert_tick_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_o |=> !sample_tick_o);

  // R5: no strobe follows a cycle in which the generator was disabled
  assert_quiet_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !sample_tick_o);

  // R4: a reload never leaves the counter at zero, so the period is at least 2
  assert_min_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_w |=> (cnt_q != Zero));
endmodule

// File: rtl/rate_octet_counter.sv
module rate_octet_counter #(
  parameter int unsigned OVERSAMPLE = 8,
  parameter int unsigned PHASE_W    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic step_i,
  output logic bit_tick_o
);
  localparam logic [PHASE_W-1:0] LastPhase = PHASE_W'(OVERSAMPLE - 1);
  localparam logic [PHASE_W-1:0] One       = PHASE_W'(1);

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               bit_q, bit_d;

  always_comb begin
    phase_d = phase_q;
    bit_d   = 1'b0;
    if (!enable_i) begin
      phase_d = '0;
    end else if (step_i) begin
      if (phase_q == LastPhase) begin
        phase_d = '0;
        bit_d   = 1'b1;
      end else begin
        phase_d = phase_q + One;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bit_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
    end
  end

  assign bit_tick_o = bit_q;

  // R7: a bit strobe never lasts two cycles
  assert_bit_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);

  // R5: the phase restarts while disabled
  assert_phase_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (phase_q == '0));
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
  import uart_rate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic [15:0] divisor_i,
  output logic        sample_tick_o,
  output logic        bit_tick_o
);
  div_t reload_val;
  logic reload_w;

  rate_reload_value #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) i_reload (
    .divisor_i (divisor_i),
    .reload_o  (reload_val)
  );

  rate_prescaler #(.DIV_W(DIV_W)) i_prescaler (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .reload_i      (reload_val),
    .reload_o      (reload_w),
    .sample_tick_o (sample_tick_o)
  );

  rate_octet_counter #(.OVERSAMPLE(OVERSAMPLE), .PHASE_W(PHASE_W)) i_octet (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .step_i     (reload_w),
    .bit_tick_o (bit_tick_o)
  );

  // R8: the bit strobe always coincides with a sample strobe
  assert_bit_on_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);
endmodule

// File: tb/test_uart_rate_gen.sv
module test_uart_rate_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LIMIT      = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [15:0] div;
  logic        s_tick, b_tick;
  int          checks = 0;
  int          fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rate_gen i_uart_rate_gen (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .divisor_i(div),
    .sample_tick_o(s_tick), .bit_tick_o(b_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until the chosen strobe is seen high (1 = sample, 0 = bit)
  task automatic gap_to(input bit sel, output int n);
    n = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      n++;
      if (sel ? s_tick : b_tick) return;
    end
    n = -1;
  endtask

  task automatic start(input logic [15:0] d);
    @(negedge clk); en = 1'b0; div = d;
    repeat (3) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset_r1;
    check("R1 sample after reset", int'(s_tick), 0);
    check("R1 bit after reset", int'(b_tick), 0);
  endtask

  task automatic t_period_r2(input logic [15:0] d);
    int g;
    start(d);
    gap_to(1'b1, g);
    gap_to(1'b1, g); check("R2 sample period", g, int'(d) + 1);
    gap_to(1'b1, g); check("R2 sample period repeat", g, int'(d) + 1);
  endtask

  task automatic t_bit_r3(input logic [15:0] d, input string tag);
    int g;
    start(d);
    gap_to(1'b0, g);
    check({tag, " bit strobe with sample"}, int'(s_tick), 1);
    gap_to(1'b0, g); check({tag, " bit period"}, g, 8 * (int'(d) + 1));
  endtask

  task automatic t_zero_r4;
    int g;
    start(16'd0);
    gap_to(1'b1, g);
    gap_to(1'b1, g); check("R4 sample period at div 0", g, 2);
    gap_to(1'b0, g);
    gap_to(1'b0, g); check("R4 bit period at div 0", g, 16);
  endtask

  task automatic t_enable_r5(input logic [15:0] d);
    int g, seen;
    seen = 0;
    @(negedge clk); en = 1'b0; div = d;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (s_tick || b_tick) seen++;
    end
    check("R5 no strobes while disabled", seen, 0);
    en = 1'b1;
    gap_to(1'b1, g); check("R5 first sample latency", g, int'(d) + 1);
    @(negedge clk); en = 1'b0;
    start(d);
    gap_to(1'b0, g); check("R5 first bit latency", g, 8 * (int'(d) + 1));
  endtask

  task automatic t_change_r6;
    int g;
    start(16'd9);
    gap_to(1'b1, g);
    repeat (2) @(negedge clk);
    div = 16'd3;
    gap_to(1'b1, g); check("R6 period in progress keeps old divisor", g + 2, 10);
    gap_to(1'b1, g); check("R6 next period uses new divisor", g, 4);
  endtask

  task automatic t_width_r7;
    int g, dbl;
    dbl = 0;
    start(16'd1);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (s_tick) begin
        @(negedge clk);
        if (s_tick) dbl++;
      end
    end
    check("R7 single-cycle sample strobe", dbl, 0);
    gap_to(1'b0, g);
    @(negedge clk); check("R7 single-cycle bit strobe", int'(b_tick), 0);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; div = 16'd0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_period_r2(16'd1);
    t_period_r2(16'd2);
    t_period_r2(16'd5);
    t_period_r2(16'd1301);
    t_bit_r3(16'd3, "R3");
    t_bit_r3(16'd7, "R3");
    t_zero_r4();
    t_enable_r5(16'd6);
    t_change_r6();
    t_width_r7();
    t_period_r2(16'd5207);
    t_bit_r3(16'd324, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule